// File: doc/BRIEF.md
# Runtime-Programmable Fibonacci Sequence Generator with Cycle-Length Measurement

This block is a Fibonacci-style linear feedback shift register whose feedback taps and starting value are written at run time. A write on the seed port is checked: a value of all zeros is refused and an error flag is raised. A nonzero value is kept as the reference seed and is also copied into the register. A separate write sets the tap mask. The lowest cell always feeds back, whatever the mask holds.

A run command reloads the register from the stored seed and starts a measurement. During the run, each cycle with the step enable high shifts the register one place toward the least significant end and presents the bit that left the bottom cell. The block counts the steps until the register holds the seed again and then reports that count as the cycle length. A run that reaches the step limit without coming back ends with a cycle length of zero, which means that no repeat was found. Seed and tap writes are refused while a run is in progress.

Top module: `prog_lfsr`

## Requirements
- R1: A step moves every cell one place toward bit 0. The bit held in cell 0 before the step appears on `bit_out` after that clock edge and stays there until the next step.
- R2: The new top cell equals the XOR of the cells selected by the tap mask before the step, where mask bit i selects cell i. Cell 0 is always included.
- R3: A seed write of zero while idle sets `seed_err` and changes neither the register nor the stored seed. A nonzero seed write while idle clears `seed_err` and shows the seed on `state_out` on the next cycle. During a run the register is never zero.
- R4: With a tap mask of zero the register rotates, so the cycle length equals WIDTH.
- R5: `run_go` starts a run only when the block is idle, a valid seed is held, and neither load strobe is high in the same cycle. Starting a run reloads the register from the seed and clears `done` and `period_out`. While idle, `step_en` has no effect.
- R6: Each cycle with `step_en` high during a run counts one step. When the register equals the seed after a step, `period_out` takes the step count, `done` goes high and the run ends.
- R7: If MAX_STEPS steps pass without a return to the seed, `done` goes high with `period_out` equal to 0.
- R8: Seed and tap writes during a run are ignored, and the run's outcome is unchanged.
- R9: A synchronous active-high reset clears the register, `bit_out`, `period_out`, `done`, `seed_err` and the valid-seed condition. After reset, `run_go` is ignored until a seed has been accepted.
- R10: With WIDTH 4, tap mask 4'b0010 and seed 4'b0101, the first fifteen output bits are 1,0,1,0,1,1,1,1,0,0,0,1,0,0,1 and the cycle length is 15.
- R11: With WIDTH 8, tap mask 8'h1D (cells 4, 3, 2 and 0), any nonzero seed gives a cycle length of 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_in | input | WIDTH | Seed value to be written |
| seed_wr | input | 1 | Seed write strobe |
| taps_in | input | WIDTH | Tap mask, bit i selects cell i |
| taps_wr | input | 1 | Tap mask write strobe |
| run_go | input | 1 | Start a measurement run |
| step_en | input | 1 | Advance one step during a run |
| bit_out | output | 1 | Bit shifted out by the latest step |
| state_out | output | WIDTH | Current register contents |
| period_out | output | $clog2(MAX_STEPS+1) | Measured cycle length, 0 if no repeat was found |
| done | output | 1 | Run finished |
| seed_err | output | 1 | Last seed write was refused as zero |

## Verification
The bound checker watches properties that hold on every cycle. These are the one-place shift and the bit that leaves the register, the ban on a zero register during a run, the refusal of a zero seed, the stability of the stored seed and mask under writes during a run, and the rule that a nonzero cycle length is reported only when the register matches the seed. Other results depend on a whole sequence of steps and can only be seen in the bench scenarios: the exact cycle lengths for rotation, for a maximal mask and for an arbitrary mask, the documented 4-bit output string, the zero result when the step limit is reached, and how strobes given in the same cycle are ordered.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Width of a counter that must reach limit inclusive.
    function automatic int count_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lfsr_seed_gate.sv
module lfsr_seed_gate #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             seed_wr,
    input  logic [WIDTH-1:0] seed_in,
    input  logic             taps_wr,
    input  logic [WIDTH-1:0] taps_in,
    output logic [WIDTH-1:0] seed_q,
    output logic [WIDTH-1:0] taps_q,
    output logic             seed_ok,
    output logic             seed_err,
    output logic             seed_take
);
    logic seed_zero;
    logic seed_reject;

    assign seed_zero   = ~|seed_in;
    assign seed_take   = idle & seed_wr & ~seed_zero;
    assign seed_reject = idle & seed_wr &  seed_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q   <= '0;
            taps_q   <= '0;
            seed_ok  <= 1'b0;
            seed_err <= 1'b0;
        end else begin
            if (seed_take) begin
                seed_q   <= seed_in;
                seed_ok  <= 1'b1;
                seed_err <= 1'b0;
            end else if (seed_reject) begin
                seed_err <= 1'b1;
            end
            if (idle && taps_wr) begin
                taps_q <= taps_in;
            end
        end
    end
endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step,
    input  logic [WIDTH-1:0] taps,
    output logic [WIDTH-1:0] cells,
    output logic [WIDTH-1:0] cells_nxt,
    output logic             bit_out
);
    logic [WIDTH-1:0] eff_taps;
    logic [WIDTH-1:0] tap_terms;
    logic             fb;

    // The bottom cell always takes part in the feedback.
    assign eff_taps = taps | {{(WIDTH-1){1'b0}}, 1'b1};

    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign tap_terms[i] = cells[i] & eff_taps[i];
    end

    assign fb        = ^tap_terms;
    assign cells_nxt = {fb, cells[WIDTH-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cells   <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            cells <= load_val;
        end else if (step) begin
            cells   <= cells_nxt;
            bit_out <= cells[0];
        end
    end
endmodule

// File: rtl/lfsr_run_ctl.sv
module lfsr_run_ctl
    import lfsr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int MAX_STEPS = 256,
    parameter int CW        = count_bits(MAX_STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_go,
    input  logic             any_wr,
    input  logic             seed_ok,
    input  logic             step_en,
    input  logic [WIDTH-1:0] cells_nxt,
    input  logic [WIDTH-1:0] seed_q,
    output logic             busy,
    output logic             start,
    output logic             adv,
    output logic [CW-1:0]    period,
    output logic             done
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_STEPS);

    phase_e      phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    assign busy  = (phase == PH_RUN);
    assign start = run_go & ~any_wr & seed_ok & ~busy;
    assign adv   = busy & step_en;
    assign cnt_n = cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            period <= '0;
            done   <= 1'b0;
        end else if (start) begin
            phase  <= PH_RUN;
            cnt    <= '0;
            period <= '0;
            done   <= 1'b0;
        end else if (adv) begin
            cnt <= cnt_n;
            if (cells_nxt == seed_q) begin
                period <= cnt_n;
                done   <= 1'b1;
                phase  <= PH_IDLE;
            end else if (cnt_n == LIMIT) begin
                period <= '0;
                done   <= 1'b1;
                phase  <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/prog_lfsr.sv
module prog_lfsr
    import lfsr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int MAX_STEPS = 256,
    localparam int PW       = count_bits(MAX_STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] seed_in,
    input  logic             seed_wr,
    input  logic [WIDTH-1:0] taps_in,
    input  logic             taps_wr,
    input  logic             run_go,
    input  logic             step_en,
    output logic             bit_out,
    output logic [WIDTH-1:0] state_out,
    output logic [PW-1:0]    period_out,
    output logic             done,
    output logic             seed_err
);
    logic [WIDTH-1:0] seed_q;
    logic [WIDTH-1:0] taps_q;
    logic [WIDTH-1:0] cells_nxt;
    logic [WIDTH-1:0] load_val;
    logic             seed_ok;
    logic             seed_take;
    logic             busy;
    logic             start;
    logic             adv;

    lfsr_seed_gate #(.WIDTH(WIDTH)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .idle     (~busy),
        .seed_wr  (seed_wr),
        .seed_in  (seed_in),
        .taps_wr  (taps_wr),
        .taps_in  (taps_in),
        .seed_q   (seed_q),
        .taps_q   (taps_q),
        .seed_ok  (seed_ok),
        .seed_err (seed_err),
        .seed_take(seed_take)
    );

    assign load_val = seed_take ? seed_in : seed_q;

    lfsr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_take | start),
        .load_val (load_val),
        .step     (adv),
        .taps     (taps_q),
        .cells    (state_out),
        .cells_nxt(cells_nxt),
        .bit_out  (bit_out)
    );

    lfsr_run_ctl #(.WIDTH(WIDTH), .MAX_STEPS(MAX_STEPS), .CW(PW)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .run_go   (run_go),
        .any_wr   (seed_wr | taps_wr),
        .seed_ok  (seed_ok),
        .step_en  (step_en),
        .cells_nxt(cells_nxt),
        .seed_q   (seed_q),
        .busy     (busy),
        .start    (start),
        .adv      (adv),
        .period   (period_out),
        .done     (done)
    );
endmodule

// File: rtl/lfsr_chk.sv
module lfsr_chk #(
    parameter int WIDTH     = 8,
    parameter int MAX_STEPS = 256,
    parameter int PW        = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             step_en,
    input logic             seed_wr,
    input logic [WIDTH-1:0] seed_in,
    input logic             taps_wr,
    input logic [WIDTH-1:0] state_out,
    input logic             bit_out,
    input logic             done,
    input logic [PW-1:0]    period_out,
    input logic             seed_err,
    input logic [WIDTH-1:0] seed_q,
    input logic [WIDTH-1:0] taps_q
);
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && step_en) |=> state_out[WIDTH-2:0] == $past(state_out[WIDTH-1:1])); // R1
    AST_BIT_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (busy && step_en) |=> bit_out == $past(state_out[0])); // R1
    AST_NO_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
        busy |-> state_out != '0); // R3
    AST_ZERO_SEED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!busy && seed_wr && seed_in == '0) |=> (seed_err && $stable(seed_q))); // R3
    AST_RETURN_MATCH: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && period_out != '0) |-> state_out == seed_q); // R6
    AST_PERIOD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done |-> period_out <= PW'(MAX_STEPS)); // R7
    AST_SEED_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && seed_wr) |=> $stable(seed_q)); // R8
    AST_TAPS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && taps_wr) |=> $stable(taps_q)); // R8
endmodule

bind prog_lfsr lfsr_chk #(.WIDTH(WIDTH), .MAX_STEPS(MAX_STEPS), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .step_en   (step_en),
    .seed_wr   (seed_wr),
    .seed_in   (seed_in),
    .taps_wr   (taps_wr),
    .state_out (state_out),
    .bit_out   (bit_out),
    .done      (done),
    .period_out(period_out),
    .seed_err  (seed_err),
    .seed_q    (seed_q),
    .taps_q    (taps_q)
);

// File: tb/sim_prog_lfsr.sv
`timescale 1ns/1ps
module sim_prog_lfsr;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic [7:0] seed_in = '0, taps_in = '0;
    logic       seed_wr = 0, taps_wr = 0, run_go = 0, step_en = 0;
    logic       bit_out, done, seed_err;
    logic [7:0] state_out;
    logic [8:0] period_out;

    prog_lfsr u0 (
        .clk(clk), .rst(rst), .seed_in(seed_in), .seed_wr(seed_wr),
        .taps_in(taps_in), .taps_wr(taps_wr), .run_go(run_go), .step_en(step_en),
        .bit_out(bit_out), .state_out(state_out), .period_out(period_out),
        .done(done), .seed_err(seed_err)
    );

    // 4-bit pair: full limit and short limit, same stimulus
    logic [3:0] s4 = '0, t4 = '0;
    logic       s4_wr = 0, t4_wr = 0, go4 = 0, st4 = 0;
    logic       b1, d1, e1, b2, d2, e2;
    logic [3:0] q1, q2;
    logic [8:0] p1;
    logic [3:0] p2;

    prog_lfsr #(.WIDTH(4), .MAX_STEPS(256)) u1 (
        .clk(clk), .rst(rst), .seed_in(s4), .seed_wr(s4_wr), .taps_in(t4), .taps_wr(t4_wr),
        .run_go(go4), .step_en(st4), .bit_out(b1), .state_out(q1), .period_out(p1),
        .done(d1), .seed_err(e1)
    );
    prog_lfsr #(.WIDTH(4), .MAX_STEPS(12)) u2 (
        .clk(clk), .rst(rst), .seed_in(s4), .seed_wr(s4_wr), .taps_in(t4), .taps_wr(t4_wr),
        .run_go(go4), .step_en(st4), .bit_out(b2), .state_out(q2), .period_out(p2),
        .done(d2), .seed_err(e2)
    );

    int nvec = 0, nfail = 0, ncyc = 0;
    bit finished = 0;

    // behavioural reference for u0
    logic [7:0] m_state, m_seed, m_taps;
    logic       m_ok, m_err, m_run, m_done, m_bit;
    int         m_cnt, m_per;

    task automatic model_step();
        int par;
        if (rst) begin
            m_state = 0; m_seed = 0; m_taps = 0; m_ok = 0; m_err = 0;
            m_run = 0; m_done = 0; m_bit = 0; m_cnt = 0; m_per = 0;
        end else if (!m_run) begin
            if (seed_wr) begin
                if (seed_in != 0) begin
                    m_seed = seed_in; m_state = seed_in; m_ok = 1; m_err = 0;
                end else m_err = 1;
            end
            if (taps_wr) m_taps = taps_in;
            if (run_go && !seed_wr && !taps_wr && m_ok) begin
                m_run = 1; m_cnt = 0; m_per = 0; m_done = 0; m_state = m_seed;
            end
        end else if (step_en) begin
            par = 0;
            for (int i = 0; i < 8; i++)
                if (m_state[i] && (m_taps[i] || i == 0)) par = par ^ 1;
            m_bit = m_state[0];
            m_state = {par[0], m_state[7:1]};
            m_cnt++;
            if (m_state == m_seed) begin
                m_per = m_cnt; m_done = 1; m_run = 0;
            end else if (m_cnt == 256) begin
                m_per = 0; m_done = 1; m_run = 0;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(bit_out == m_bit, "R1 bit_out", bit_out, m_bit);
        chk(state_out == m_state, "R2 state_out", state_out, m_state);
        chk(seed_err == m_err, "R3 seed_err", seed_err, m_err);
        chk(done == m_done, "R6 done", done, m_done);
        chk(period_out == 9'(m_per), "R6 period_out", period_out, m_per);
    endtask

    task automatic load(input logic [7:0] s, input logic [7:0] t);
        seed_in = s; taps_in = t; seed_wr = 1; taps_wr = 1;
        cyc();
        seed_wr = 0; taps_wr = 0;
    endtask

    task automatic start_run();
        run_go = 1; cyc(); run_go = 0;
    endtask

    task automatic do_run(input int gap);
        for (int i = 0; i < 1200 && m_run; i++) begin
            step_en = (gap == 0) || (i % gap != 0);
            cyc();
        end
        step_en = 0;
        cyc();
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000 && !finished) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", ncyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [14:0] got;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R9 reset state
        chk(state_out == 0 && done == 0 && seed_err == 0 && period_out == 0 && bit_out == 0,
            "R9 reset", {state_out, done, seed_err}, 0);
        start_run(); cyc();
        chk(done == 0 && state_out == 0, "R9 run without seed", state_out, 0);

        // R3 zero seed refused
        seed_in = 0; seed_wr = 1; cyc(); seed_wr = 0; cyc();
        chk(seed_err == 1 && state_out == 0, "R3 zero seed", seed_err, 1);
        load(8'h01, 8'h00); cyc();
        chk(seed_err == 0 && state_out == 8'h01, "R3 nonzero seed", state_out, 8'h01);

        // R5 step while idle has no effect
        step_en = 1; cyc(); step_en = 0; cyc();
        chk(state_out == 8'h01, "R5 idle step", state_out, 8'h01);

        // R4 rotation
        start_run(); do_run(0);
        chk(done == 1 && period_out == 8, "R4 rotate period", period_out, 8);

        // R11 maximal mask with gaps in the enable, plus R8 writes during run
        load(8'hA5, 8'h1D); start_run();
        step_en = 1; repeat (5) cyc();
        seed_in = 8'h11; taps_in = 8'hFF; seed_wr = 1; taps_wr = 1; cyc();
        seed_in = 8'h00; cyc();
        seed_wr = 0; taps_wr = 0;
        chk(seed_err == 0, "R8 zero write in run ignored", seed_err, 0);
        do_run(3);
        chk(done == 1 && period_out == 255, "R11 maximal period", period_out, 255);
        chk(state_out == 8'hA5, "R8 seed kept", state_out, 8'hA5);

        // R5 load and run in the same cycle: load wins, no run
        seed_in = 8'h3C; taps_in = 8'h5A; seed_wr = 1; taps_wr = 1; run_go = 1; cyc();
        seed_wr = 0; taps_wr = 0; run_go = 0;
        step_en = 1; cyc(); step_en = 0; cyc();
        chk(state_out == 8'h3C && done == 1 && period_out == 255, "R5 load beats run",
            state_out, 8'h3C);

        // R6 arbitrary mask
        start_run();
        chk(done == 0 && period_out == 0, "R5 run clears result", done, 0);
        do_run(0);
        chk(done == 1 && period_out == 9'(m_per) && m_per != 0, "R6 arbitrary period",
            period_out, m_per);

        // R2 single steps against hand-computed values: seed 0x81 taps 0x80
        load(8'h81, 8'h80); start_run();
        step_en = 1; cyc(); step_en = 0;
        chk(state_out == 8'h40 && bit_out == 1, "R2 feedback 1^1", state_out, 8'h40);
        step_en = 1; cyc(); step_en = 0;
        chk(state_out == 8'h20 && bit_out == 0, "R2 feedback 0^0", state_out, 8'h20);

        // R9 reset mid-run
        rst = 1; cyc(); rst = 0; cyc();
        chk(state_out == 0 && done == 0 && seed_err == 0 && period_out == 0, "R9 mid-run reset",
            state_out, 0);
        start_run(); step_en = 1; cyc(); step_en = 0;
        chk(state_out == 0, "R9 run ignored after reset", state_out, 0);

        // R10 / R7 on the 4-bit pair
        s4 = 4'b0101; t4 = 4'b0010; s4_wr = 1; t4_wr = 1; cyc();
        s4_wr = 0; t4_wr = 0; go4 = 1; cyc(); go4 = 0;
        got = '0;
        for (int k = 0; k < 15; k++) begin
            st4 = 1; cyc();
            got = {got[13:0], b1};
        end
        st4 = 0; cyc();
        chk(got == 15'b101011110001001, "R10 output bits", got, 15'b101011110001001);
        chk(d1 == 1 && p1 == 15 && q1 == 4'b0101, "R10 period", p1, 15);
        chk(d2 == 1 && p2 == 0, "R7 limit reached", p2, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule